// File: doc/BRIEF.md
# Latched Address One-of-Eight Decoder

This block turns a 3-bit select value into a single active line on an 8-bit output bus. An address hold stage sits in front of the decoder. While the hold control is low the stage passes the select inputs straight through. While it is high the stage keeps the address it last took in, so the output stays put when the select inputs change.

Two output enables gate the decoded result, one active high and one active low. When either enable is inactive, every output line goes to its idle level. Holding one enable active and driving data on the other makes the block a 1-to-8 demultiplexer, and the opposite polarities make cascading simple.

A build parameter sets the output sense: the active line is either high among lows or low among highs. A second parameter chooses how the hold stage is built: a clocked register or a level-sensitive latch. The output bus is registered and has one clock of latency from any input.

Top module: `latched_decoder`

## Requirements
- R1: With both enables active, select value k (sel[0] the least significant bit) makes output bit k the only active line, one clock edge after the inputs are applied.
- R2: While hold is 0, the output follows each new select value with the one-edge latency of R1.
- R3: While hold is 1, the decoder uses the select value present at the last edge where hold was 0. Later select changes leave the output unchanged.
- R4: en_hi is active when 1 and en_lo_n is active when 0. Decoding requires both to be active at the same edge.
- R5: If en_hi is 0 or en_lo_n is 1, all eight outputs go to the idle level one edge later, whatever the values of sel and hold.
- R6: With INVERT_OUT=0 the active line is 1, the others are 0, and the idle level is 0. With INVERT_OUT=1 the active line is 0, the others are 1, and the idle level is 1.
- R7: The enables do not touch the hold stage. An address taken while the outputs are disabled appears once the enables return, and it still appears if hold was raised while the outputs were disabled.
- R8: Synchronous reset (rst=1) drives the outputs to the idle level and clears the held address to 0. After reset, with hold=1, enabling the outputs activates bit 0.
- R9: With en_lo_n held at 0 and sel fixed, the selected output bit carries the value of en_hi, one edge later and in the polarity of R6, while all other bits stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | SEL_W (3) | Select value, bit 0 least significant |
| hold | input | 1 | 0 = pass the select through, 1 = keep the held address |
| en_hi | input | 1 | Output enable, active high (data input in demux use) |
| en_lo_n | input | 1 | Output enable, active low |
| y | output | 2**SEL_W (8) | Registered decoded outputs |

## Verification
The bench builds two copies side by side and drives them with the same stimulus. The first uses INVERT_OUT=0 with the clocked register hold stage. The second uses INVERT_OUT=1 with the level-sensitive latch hold stage. Every vector therefore checks both output senses, and it shows that the two hold-stage builds give identical cycle-level results for transparency, holding, reset clearing and enable gating.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  // Both enables must be in their active state for decoding.
  function automatic logic both_enabled(input logic hi, input logic lo_n);
    return hi & ~lo_n;
  endfunction
endpackage

// File: rtl/lcd_addr_hold.sv
module lcd_addr_hold #(
  parameter int SEL_W     = 3,
  parameter bit USE_LATCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             hold,
  output logic [SEL_W-1:0] addr
);
  generate
    if (USE_LATCH) begin : g_latch
      logic [SEL_W-1:0] lat_q;
      always_latch begin
        if (rst)        lat_q = '0;
        else if (!hold) lat_q = sel;
      end
      assign addr = lat_q;
    end else begin : g_reg
      logic [SEL_W-1:0] addr_q;
      always_ff @(posedge clk) begin
        if (rst)        addr_q <= '0;
        else if (!hold) addr_q <= sel;
      end
      // Pass-through when not holding, stored value otherwise.
      assign addr = hold ? addr_q : sel;

      assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(addr_q));
      assert_open_captures_R2: assert property (@(posedge clk) disable iff (rst)
        !hold |=> addr_q == $past(sel));
    end
  endgenerate
endmodule

// File: rtl/lcd_onehot.sv
module lcd_onehot #(
  parameter int SEL_W = 3,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] addr,
  output logic [N_OUT-1:0] hot
);
  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_line
      assign hot[i] = (addr == SEL_W'(i));
    end
  endgenerate
endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage #(
  parameter int N_OUT      = 8,
  parameter bit INVERT_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] hot,
  input  logic             en_hi,
  input  logic             en_lo_n,
  output logic [N_OUT-1:0] y
);
  import lcd_pkg::*;
  localparam logic [N_OUT-1:0] POL_MASK = {N_OUT{INVERT_OUT}};

  logic [N_OUT-1:0] gated;
  logic [N_OUT-1:0] act;

  assign gated = both_enabled(en_hi, en_lo_n) ? hot : '0;

  always_ff @(posedge clk) begin
    if (rst) y <= POL_MASK;
    else     y <= gated ^ POL_MASK;
  end

  assign act = y ^ POL_MASK;

  assert_single_active_R1: assert property (@(posedge clk) disable iff (rst)
    (en_hi && !en_lo_n) |=> $countones(act) == 1);
  assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_hi || en_lo_n) |=> act == '0);
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int SEL_W      = 3,
  parameter bit INVERT_OUT = 1'b0,
  parameter bit USE_LATCH  = 1'b0,
  localparam int N_OUT     = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             hold,
  input  logic             en_hi,
  input  logic             en_lo_n,
  output logic [N_OUT-1:0] y
);
  logic [SEL_W-1:0] eff_addr;
  logic [N_OUT-1:0] hot;

  lcd_addr_hold #(.SEL_W(SEL_W), .USE_LATCH(USE_LATCH)) u_hold (
    .clk(clk), .rst(rst), .sel(sel), .hold(hold), .addr(eff_addr)
  );

  lcd_onehot #(.SEL_W(SEL_W)) u_dec (
    .addr(eff_addr), .hot(hot)
  );

  lcd_out_stage #(.N_OUT(N_OUT), .INVERT_OUT(INVERT_OUT)) u_out (
    .clk(clk), .rst(rst), .hot(hot), .en_hi(en_hi), .en_lo_n(en_lo_n), .y(y)
  );

  logic [N_OUT-1:0] y_act;
  assign y_act = y ^ {N_OUT{INVERT_OUT}};

  assert_line_matches_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (en_hi && !en_lo_n) |=> y_act[$past(eff_addr)]);
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (y_act == '0));
endmodule

// File: tb/latched_decoder_bench.sv
module latched_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 3;
  localparam int N_OUT = 1 << SEL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SEL_W-1:0] sel = '0;
  logic hold = 1'b0;
  logic en_hi = 1'b0;
  logic en_lo_n = 1'b1;
  logic [N_OUT-1:0] y_pos, y_neg;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_decoder #(.SEL_W(SEL_W), .INVERT_OUT(1'b0), .USE_LATCH(1'b0)) u_latched_decoder (
    .clk(clk), .rst(rst), .sel(sel), .hold(hold), .en_hi(en_hi), .en_lo_n(en_lo_n), .y(y_pos)
  );

  latched_decoder #(.SEL_W(SEL_W), .INVERT_OUT(1'b1), .USE_LATCH(1'b1)) u_latched_decoder_inv (
    .clk(clk), .rst(rst), .sel(sel), .hold(hold), .en_hi(en_hi), .en_lo_n(en_lo_n), .y(y_neg)
  );

  function automatic logic [N_OUT-1:0] expv(input int idx, input bit on, input bit inv);
    logic [N_OUT-1:0] v;
    v = on ? (N_OUT'(1) << idx) : '0;
    return inv ? ~v : v;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Wait for the next falling edge (one rising edge after the last drive) and compare.
  task automatic chk(input string req, input int idx, input bit on);
    logic [N_OUT-1:0] e0, e1;
    @(negedge clk);
    e0 = expv(idx, on, 1'b0);
    e1 = expv(idx, on, 1'b1);
    vectors += 2;
    if (y_pos !== e0) begin
      miscompares++;
      $display("FAIL %s (INVERT_OUT=0): got %b expected %b", req, y_pos, e0);
    end
    if (y_neg !== e1) begin
      miscompares++;
      $display("FAIL %s (INVERT_OUT=1): got %b expected %b", req, y_neg, e1);
    end
  endtask

  task automatic drive(input int s, input bit h, input bit eh, input bit el);
    sel = SEL_W'(s); hold = h; en_hi = eh; en_lo_n = el;
  endtask

  task automatic t_reset();
    drive(6, 1'b1, 1'b1, 1'b0);
    rst = 1'b1;
    chk("R8 reset idle", 0, 1'b0);
    chk("R8 reset idle", 0, 1'b0);
    rst = 1'b0;
    chk("R8 held address cleared to 0", 0, 1'b1);
  endtask

  task automatic t_transparent();
    for (int k = 0; k < N_OUT; k++) begin
      drive(k, 1'b0, 1'b1, 1'b0);
      chk("R1 R2 R6 decode", k, 1'b1);
    end
    for (int k = N_OUT - 1; k >= 0; k -= 3) begin
      drive(k, 1'b0, 1'b1, 1'b0);
      chk("R2 follow descending", k, 1'b1);
    end
  endtask

  task automatic t_hold();
    drive(5, 1'b0, 1'b1, 1'b0);
    chk("R2 before hold", 5, 1'b1);
    drive(5, 1'b1, 1'b1, 1'b0);
    chk("R3 hold raised", 5, 1'b1);
    drive(2, 1'b1, 1'b1, 1'b0);
    chk("R3 sel change ignored", 5, 1'b1);
    drive(7, 1'b1, 1'b1, 1'b0);
    chk("R3 sel change ignored", 5, 1'b1);
    drive(7, 1'b0, 1'b1, 1'b0);
    chk("R2 hold released", 7, 1'b1);
  endtask

  task automatic t_enables();
    drive(1, 1'b0, 1'b0, 1'b0);
    chk("R4 R5 en_hi inactive", 1, 1'b0);
    drive(1, 1'b0, 1'b1, 1'b1);
    chk("R4 R5 en_lo_n inactive", 1, 1'b0);
    drive(1, 1'b0, 1'b0, 1'b1);
    chk("R5 both inactive", 1, 1'b0);
    drive(1, 1'b0, 1'b1, 1'b0);
    chk("R4 both active", 1, 1'b1);
    drive(6, 1'b1, 1'b0, 1'b1);
    chk("R5 idle while holding", 6, 1'b0);
  endtask

  task automatic t_indep();
    drive(3, 1'b0, 1'b0, 1'b1);
    chk("R7 disabled capture", 3, 1'b0);
    drive(3, 1'b1, 1'b0, 1'b1);
    chk("R7 hold while disabled", 3, 1'b0);
    drive(6, 1'b1, 1'b0, 1'b1);
    chk("R7 sel change while disabled", 3, 1'b0);
    drive(6, 1'b1, 1'b1, 1'b0);
    chk("R7 held address after enable", 3, 1'b1);
    drive(4, 1'b0, 1'b0, 1'b1);
    chk("R7 open while disabled", 4, 1'b0);
    drive(4, 1'b0, 1'b1, 1'b0);
    chk("R7 captured address shown", 4, 1'b1);
  endtask

  task automatic t_demux();
    bit pattern [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 6; i++) begin
      drive(4, 1'b0, pattern[i], 1'b0);
      chk("R9 demux data", 4, pattern[i]);
    end
    for (int i = 0; i < 4; i++) begin
      drive(2, 1'b1, pattern[i], 1'b0);
      chk("R9 demux on held address", 4, pattern[i]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        miscompares++;
        $display("FAIL watchdog: got %0d cycles expected at most 5000", cycles);
        summary();
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_transparent();
    t_hold();
    t_enables();
    t_indep();
    t_demux();
    summary();
  end
endmodule